// File: doc/BRIEF.md
# Upstream Register Window Gate

This block stands at the upstream port of a switch, in front of the internal register space. Every request that reaches it carries a type (configuration or memory), a direction, an address, a flag for a 64-bit address, a length in dwords, four byte enables and write data. Configuration requests are always claimed and use the low twelve address bits as the register offset. A memory request is claimed only if it falls inside a programmable 128 KB window. The window is set by a base register pair with a selectable 32-bit or 64-bit type, and it can be gated off by the command register and by a disable control.

For each claimed request the block returns one completion, one cycle after the request. The completion carries a status of success, Unsupported Request or Completer Abort, together with read data. Error outcomes latch sticky status bits, which software clears by writing ones. The register set is small: a command register, the base pair, a device status word, an uncorrectable error status word, a control word, and a bank of scratch words in the device-specific range. Offsets that have no register read as zero.

Top module: `regwin_gate`

## Requirements
- R1: After reset, a configuration read of the command (04h), base low (10h), base high (14h), device status (70h) and error status (FB8h) words returns 0 with success status (code 0).
- R2: In the base low word, only bits [31:17] and bit 2 hold written values. Bit 2 set selects the 64-bit type, so bits [2:1] read 10b; bit 2 clear selects the 32-bit type and bits [2:1] read 00b. Bit 3, bits [16:4], bit 1 and bit 0 always read 0.
- R3: While the 32-bit type is selected, the base high word reads 0 and ignores writes. Writing the base low word with the 32-bit type clears the base high word.
- R4: With command bit 1 set and the disable control clear, a memory request with a 32-bit address is claimed when address bits [31:17] equal the base. This holds in 32-bit type, and in 64-bit type when the base high word is 0. Register offset = address bits [11:0]. Window offsets at 1000h and above read 0.
- R5: In 64-bit type with a nonzero base high word, a memory request is claimed only if it carries a 64-bit address whose bits [63:32] equal the base high word and whose bits [31:17] match. A 32-bit address misses.
- R6: In 64-bit type with the base high word 0, a memory request with a 64-bit address whose bits [31:17] match is claimed with Unsupported Request (code 1). It returns zero data and writes nothing. It sets error status bit 20 and device status bit 19.
- R7: A memory request made while command bit 1 is clear, or while control word 660h bit 25 is set, gets no completion and has no register effect. Configuration requests are unaffected.
- R8: Writes update only the bytes whose enables are set. Read data bytes whose enables are clear return 0.
- R9: A claimed request with a length other than 1 completes with Completer Abort (code 2). A read returns the first dword; a write is discarded. Either case sets error status bit 15 and device status bit 17.
- R10: A configuration request to offsets 600h–7FFh completes with success, returns zero data and discards write data. Memory requests reach those registers.
- R11: The error status and device status bits are cleared by writing 1 to them.
- R12: A completion appears exactly one cycle after each claimed request. A memory request that misses the window produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_mem | input | 1 | 1 = memory request, 0 = configuration request |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_addr64 | input | 1 | Request carries a 64-bit address |
| req_addr | input | 64 | Byte address (configuration: offset in bits [11:0]) |
| req_len | input | 10 | Length in dwords |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | Completion for a claimed request |
| cpl_status | output | 2 | 0 success, 1 Unsupported Request, 2 Completer Abort |
| cpl_rdata | output | 32 | Read data |

## Verification
The assertions watch every cycle for the timing and gating rules. Idle cycles and memory requests made while decoding is off never produce a completion. Over-length requests always end in Completer Abort. Every abort or Unsupported Request completion finds its sticky error bit already set, and the base high word stays zero while the 32-bit type is selected. Only the bench scenarios can show the data-dependent behaviour: the field masking of the base word, address matching under both types, byte-enable merging, zero data on device-specific configuration reads, and write-one-to-clear.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_UNSUP = 2'd1,
      ST_ABORT = 2'd2
   } cpl_st_e;

   localparam int unsigned OFS_CMD   = 12'h004;
   localparam int unsigned OFS_BASLO = 12'h010;
   localparam int unsigned OFS_BASHI = 12'h014;
   localparam int unsigned OFS_DSTAT = 12'h070;
   localparam int unsigned OFS_CTRL  = 12'h660;
   localparam int unsigned OFS_UESTA = 12'hFB8;

   localparam int unsigned BIT_MEMEN   = 1;
   localparam int unsigned BIT_BAROFF  = 25;
   localparam int unsigned BIT_UE_CA   = 15;
   localparam int unsigned BIT_UE_UR   = 20;
   localparam int unsigned BIT_DS_NF   = 17;
   localparam int unsigned BIT_DS_UR   = 19;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode #(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned LEN_W    = 10,
   parameter int unsigned WIN_BITS = 17,
   parameter int unsigned DEV_LO   = 12'h600,
   parameter int unsigned DEV_HI   = 12'h800
) (
   input  logic                  is_mem,
   input  logic                  addr64,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [LEN_W-1:0]      len,
   input  logic                  mem_en,
   input  logic                  win_off,
   input  logic [31:WIN_BITS]    base_lo,
   input  logic                  base_is64,
   input  logic [31:0]           base_hi,
   output logic                  claim,
   output logic                  unsup,
   output logic                  overlen,
   output logic                  in_space,
   output logic                  dev_spec,
   output logic [9:0]            idx
);
   localparam int unsigned HI_W = ADDR_W - 32;

   logic            lo_match;
   logic            hi_zero;
   logic            gate_on;
   logic [1:0]      unused_lsb;

   assign unused_lsb = addr[1:0];
   assign lo_match   = (addr[31:WIN_BITS] == base_lo);
   assign hi_zero    = (base_hi == 32'd0);
   assign gate_on    = mem_en && !win_off;

   always_comb begin
      claim = 1'b0;
      unsup = 1'b0;
      if (!is_mem) begin
         claim = 1'b1;
      end else if (gate_on && lo_match) begin
         if (!addr64) begin
            claim = !base_is64 || hi_zero;
         end else if (base_is64) begin
            if (hi_zero) begin
               claim = 1'b1;
               unsup = 1'b1;
            end else if (addr[ADDR_W-1:32] == base_hi[HI_W-1:0]) begin
               claim = 1'b1;
            end
         end
      end
   end

   assign overlen  = (len != LEN_W'(1));
   assign in_space = !is_mem || (addr[WIN_BITS-1:12] == '0);
   assign dev_spec = (32'(addr[11:0]) >= DEV_LO) && (32'(addr[11:0]) < DEV_HI);
   assign idx      = addr[11:2];
endmodule

// File: rtl/regwin_regs.sv
module regwin_regs
   import regwin_pkg::*;
#(
   parameter int unsigned WIN_BITS  = 17,
   parameter int unsigned SCR_WORDS = 16,
   parameter int unsigned DEV_LO    = 12'h600
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [9:0]            idx,
   input  logic [3:0]            be,
   input  logic [31:0]           wdata,
   input  logic                  set_ca,
   input  logic                  set_ur,
   output logic [31:0]           rdata,
   output logic                  mem_en,
   output logic                  win_off,
   output logic [31:WIN_BITS]    base_lo,
   output logic                  base_is64,
   output logic [31:0]           base_hi,
   output logic                  flag_ca,
   output logic                  flag_ur
);
   localparam logic [9:0] I_CMD   = 10'(OFS_CMD   >> 2);
   localparam logic [9:0] I_BASLO = 10'(OFS_BASLO >> 2);
   localparam logic [9:0] I_BASHI = 10'(OFS_BASHI >> 2);
   localparam logic [9:0] I_DSTAT = 10'(OFS_DSTAT >> 2);
   localparam logic [9:0] I_CTRL  = 10'(OFS_CTRL  >> 2);
   localparam logic [9:0] I_UESTA = 10'(OFS_UESTA >> 2);
   localparam int unsigned SCR_BASE = DEV_LO >> 2;

   logic [31:0] wm;
   logic [31:0] bem;
   logic [1:0]  cmd_q;
   logic        ds_nf_q, ds_ur_q;
   logic [31:0] scr [SCR_WORDS];
   logic [31:0] rd_raw;
   logic        clr_ue, clr_ds;

   assign wm  = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   assign bem = wm;
   assign mem_en = cmd_q[BIT_MEMEN-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= 2'b00;
         base_lo   <= '0;
         base_is64 <= 1'b0;
         base_hi   <= 32'd0;
         win_off   <= 1'b0;
      end else if (wr_en) begin
         case (idx)
            I_CMD:   if (be[0]) cmd_q <= wdata[2:1];
            I_BASLO: begin
               base_lo <= (base_lo & ~wm[31:WIN_BITS]) | (wdata[31:WIN_BITS] & wm[31:WIN_BITS]);
               if (be[0]) begin
                  base_is64 <= wdata[2];
                  if (!wdata[2]) base_hi <= 32'd0;
               end
            end
            I_BASHI: if (base_is64) base_hi <= (base_hi & ~wm) | (wdata & wm);
            I_CTRL:  if (be[3]) win_off <= wdata[BIT_BAROFF];
            default: ;
         endcase
      end
   end

   assign clr_ue = wr_en && (idx == I_UESTA);
   assign clr_ds = wr_en && (idx == I_DSTAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_ca <= 1'b0;
         flag_ur <= 1'b0;
         ds_nf_q <= 1'b0;
         ds_ur_q <= 1'b0;
      end else begin
         flag_ca <= set_ca | (flag_ca & ~(clr_ue & wm[BIT_UE_CA] & wdata[BIT_UE_CA]));
         flag_ur <= set_ur | (flag_ur & ~(clr_ue & wm[BIT_UE_UR] & wdata[BIT_UE_UR]));
         ds_nf_q <= set_ca | (ds_nf_q & ~(clr_ds & wm[BIT_DS_NF] & wdata[BIT_DS_NF]));
         ds_ur_q <= set_ur | (ds_ur_q & ~(clr_ds & wm[BIT_DS_UR] & wdata[BIT_DS_UR]));
      end
   end

   for (genvar w = 0; w < SCR_WORDS; w++) begin : g_scr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            scr[w] <= 32'd0;
         end else if (wr_en && idx == 10'(SCR_BASE + w)) begin
            for (int b = 0; b < 4; b++) begin
               if (be[b]) scr[w][b*8 +: 8] <= wdata[b*8 +: 8];
            end
         end
      end
   end

   always_comb begin
      rd_raw = 32'd0;
      case (idx)
         I_CMD:   rd_raw = {29'd0, cmd_q, 1'b0};
         I_BASLO: rd_raw = {base_lo, {(WIN_BITS-4){1'b0}}, 1'b0, base_is64, 2'b00};
         I_BASHI: rd_raw = base_hi;
         I_DSTAT: begin
            rd_raw[BIT_DS_NF] = ds_nf_q;
            rd_raw[BIT_DS_UR] = ds_ur_q;
         end
         I_CTRL:  rd_raw[BIT_BAROFF] = win_off;
         I_UESTA: begin
            rd_raw[BIT_UE_CA] = flag_ca;
            rd_raw[BIT_UE_UR] = flag_ur;
         end
         default: begin
            for (int w = 0; w < SCR_WORDS; w++) begin
               if (idx == 10'(SCR_BASE + w)) rd_raw = scr[w];
            end
         end
      endcase
   end

   assign rdata = rd_en ? (rd_raw & bem) : 32'd0;

   // R3: high base word held at zero under the 32-bit type
   a_r3_hi_zero_in_32: assert property (@(posedge clk) disable iff (!rst_n)
      !base_is64 |-> (base_hi == 32'd0));
endmodule

// File: rtl/regwin_gate.sv
module regwin_gate
   import regwin_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned LEN_W     = 10,
   parameter int unsigned WIN_BITS  = 17,
   parameter int unsigned SCR_WORDS = 16,
   parameter int unsigned DEV_LO    = 12'h600,
   parameter int unsigned DEV_HI    = 12'h800
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_is_mem,
   input  logic               req_is_write,
   input  logic               req_addr64,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [LEN_W-1:0]   req_len,
   input  logic [3:0]         req_be,
   input  logic [31:0]        req_wdata,
   output logic               cpl_valid,
   output logic [1:0]         cpl_status,
   output logic [31:0]        cpl_rdata
);
   if (WIN_BITS < 13 || WIN_BITS > 31) begin : g_bad_win
      $error("WIN_BITS must lie in 13..31");
   end
   if (ADDR_W != 64) begin : g_bad_addr
      $error("ADDR_W must be 64");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("LEN_W must be at least 2");
   end
   if (DEV_HI <= DEV_LO || DEV_HI > 12'hFB8 || SCR_WORDS * 4 > DEV_HI - DEV_LO
       || DEV_LO + SCR_WORDS * 4 > OFS_CTRL) begin : g_bad_dev
      $error("device-specific range does not fit");
   end

   logic                  claim, unsup, overlen, in_space, dev_spec;
   logic [9:0]            idx;
   logic                  mem_en, win_off, base_is64, flag_ca, flag_ur;
   logic [31:WIN_BITS]    base_lo;
   logic [31:0]           base_hi, rdata;
   logic                  acc, blocked, wr_en, rd_en, set_ca, set_ur;

   regwin_decode #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WIN_BITS(WIN_BITS),
      .DEV_LO(DEV_LO), .DEV_HI(DEV_HI)
   ) u_dec (
      .is_mem(req_is_mem), .addr64(req_addr64), .addr(req_addr), .len(req_len),
      .mem_en(mem_en), .win_off(win_off), .base_lo(base_lo),
      .base_is64(base_is64), .base_hi(base_hi),
      .claim(claim), .unsup(unsup), .overlen(overlen),
      .in_space(in_space), .dev_spec(dev_spec), .idx(idx)
   );

   assign acc     = req_valid && claim && !unsup;
   assign blocked = (!req_is_mem && dev_spec) || !in_space;
   assign wr_en   = acc && req_is_write && !overlen && !blocked;
   assign rd_en   = acc && !req_is_write && !blocked;
   assign set_ca  = acc && overlen;
   assign set_ur  = req_valid && claim && unsup;

   regwin_regs #(
      .WIN_BITS(WIN_BITS), .SCR_WORDS(SCR_WORDS), .DEV_LO(DEV_LO)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
      .be(req_be), .wdata(req_wdata), .set_ca(set_ca), .set_ur(set_ur),
      .rdata(rdata), .mem_en(mem_en), .win_off(win_off), .base_lo(base_lo),
      .base_is64(base_is64), .base_hi(base_hi),
      .flag_ca(flag_ca), .flag_ur(flag_ur)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpl_valid  <= 1'b0;
         cpl_status <= ST_OK;
         cpl_rdata  <= 32'd0;
      end else begin
         cpl_valid  <= req_valid && claim;
         cpl_status <= unsup ? ST_UNSUP : (overlen ? ST_ABORT : ST_OK);
         cpl_rdata  <= rdata;
      end
   end

   // R12: no completion without a request
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !cpl_valid);
   // R7: memory decode gated by command and disable control
   a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_mem && (!mem_en || win_off)) |=> !cpl_valid);
   // R9: over-length claimed request ends in abort
   a_r9_overlen_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && claim && !unsup && overlen) |=> (cpl_valid && cpl_status == ST_ABORT));
   // R9: abort completion finds its status bit set
   a_r9_abort_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_status == ST_ABORT) |-> flag_ca);
   // R6: unsupported completion finds its status bit set
   a_r6_unsup_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_status == ST_UNSUP) |-> flag_ur);
endmodule

// File: tb/sim_regwin_gate.sv
module sim_regwin_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_is_mem = 1'b0;
   logic        req_is_write = 1'b0;
   logic        req_addr64 = 1'b0;
   logic [63:0] req_addr = 64'd0;
   logic [9:0]  req_len = 10'd1;
   logic [3:0]  req_be = 4'hF;
   logic [31:0] req_wdata = 32'd0;
   logic        cpl_valid;
   logic [1:0]  cpl_status;
   logic [31:0] cpl_rdata;

   int n_chk = 0;
   int n_fail = 0;
   logic        g_v;
   logic [1:0]  g_st;
   logic [31:0] g_d;

   always #10 clk = ~clk;

   regwin_gate u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_mem(req_is_mem),
      .req_is_write(req_is_write), .req_addr64(req_addr64), .req_addr(req_addr),
      .req_len(req_len), .req_be(req_be), .req_wdata(req_wdata),
      .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_rdata(cpl_rdata)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic send(input logic mem, input logic wr, input logic a64,
                       input logic [63:0] a, input logic [9:0] len,
                       input logic [3:0] be, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_is_mem = mem; req_is_write = wr; req_addr64 = a64;
      req_addr = a; req_len = len; req_be = be; req_wdata = wd;
      @(negedge clk);
      g_v = cpl_valid; g_st = cpl_status; g_d = cpl_rdata;
      req_valid = 1'b0;
   endtask

   task automatic cfg_rd(input logic [11:0] ofs);
      send(1'b0, 1'b0, 1'b0, {52'd0, ofs}, 10'd1, 4'hF, 32'd0);
   endtask
   task automatic cfg_wr(input logic [11:0] ofs, input logic [31:0] d);
      send(1'b0, 1'b1, 1'b0, {52'd0, ofs}, 10'd1, 4'hF, d);
   endtask

   task automatic t_reset;
      cfg_rd(12'h004); check("R1 cmd", g_d, 0); check("R1 status", {30'd0, g_st}, 0);
      cfg_rd(12'h010); check("R1 base lo", g_d, 0);
      cfg_rd(12'h014); check("R1 base hi", g_d, 0);
      cfg_rd(12'h070); check("R1 dstat", g_d, 0);
      cfg_rd(12'hFB8); check("R1 uesta", g_d, 0);
   endtask

   task automatic t_fields;
      cfg_wr(12'h010, 32'hFFFF_FFFF); cfg_rd(12'h010); check("R2 all ones 64", g_d, 32'hFFFE_0004);
      cfg_wr(12'h010, 32'hFFFF_FFF9); cfg_rd(12'h010); check("R2 bit3 ignored", g_d, 32'hFFFE_0000);
      cfg_wr(12'h014, 32'h0000_1234); cfg_rd(12'h014); check("R3 hi ignored in 32", g_d, 0);
   endtask

   task automatic t_dec32;
      cfg_wr(12'h010, 32'h8002_0000);
      cfg_wr(12'h004, 32'h0000_0006);
      send(1, 0, 0, 64'h8002_0010, 1, 4'hF, 0);
      check("R4 hit valid", {31'd0, g_v}, 1); check("R4 hit data", g_d, 32'h8002_0000);
      send(1, 0, 0, 64'h8004_0010, 1, 4'hF, 0); check("R12 miss no cpl", {31'd0, g_v}, 0);
      send(1, 0, 1, 64'h8002_0010, 1, 4'hF, 0); check("R4 a64 in 32 miss", {31'd0, g_v}, 0);
      send(1, 0, 0, 64'h8002_1010, 1, 4'hF, 0);
      check("R4 above 4K valid", {31'd0, g_v}, 1); check("R4 above 4K zero", g_d, 0);
   endtask

   task automatic t_be;
      send(1, 1, 0, 64'h8002_0604, 1, 4'b0101, 32'hAABB_CCDD);
      send(1, 0, 0, 64'h8002_0604, 1, 4'hF, 0); check("R8 partial write", g_d, 32'h00BB_00DD);
      send(1, 0, 0, 64'h8002_0604, 1, 4'b0100, 0); check("R8 read mask", g_d, 32'h00BB_0000);
   endtask

   task automatic t_overlen;
      send(1, 0, 0, 64'h8002_0010, 2, 4'hF, 0);
      check("R9 first dword", g_d, 32'h8002_0000); check("R9 abort", {30'd0, g_st}, 2);
      cfg_rd(12'hFB8); check("R9 ue bit15", g_d, 32'h0000_8000);
      cfg_rd(12'h070); check("R9 ds bit17", g_d, 32'h0002_0000);
      send(1, 1, 0, 64'h8002_0608, 2, 4'hF, 32'h1234_5678); check("R9 write abort", {30'd0, g_st}, 2);
      send(1, 0, 0, 64'h8002_0608, 1, 4'hF, 0); check("R9 write discarded", g_d, 0);
      cfg_wr(12'hFB8, 32'h0000_8000); cfg_rd(12'hFB8); check("R11 ue clear", g_d, 0);
      cfg_wr(12'h070, 32'h0002_0000); cfg_rd(12'h070); check("R11 ds clear", g_d, 0);
   endtask

   task automatic t_devcfg;
      cfg_rd(12'h604);
      check("R10 cfg valid", {31'd0, g_v}, 1); check("R10 cfg zero", g_d, 0);
      check("R10 cfg ok", {30'd0, g_st}, 0);
      cfg_wr(12'h604, 32'h1111_1111);
      send(1, 0, 0, 64'h8002_0604, 1, 4'hF, 0); check("R10 cfg write dropped", g_d, 32'h00BB_00DD);
   endtask

   task automatic t_dec64;
      cfg_wr(12'h010, 32'h8002_0004); cfg_rd(12'h010); check("R2 type 64", g_d, 32'h8002_0004);
      send(1, 0, 1, 64'h0000_0000_8002_0010, 1, 4'hF, 0);
      check("R6 claimed", {31'd0, g_v}, 1); check("R6 unsup", {30'd0, g_st}, 1);
      check("R6 zero data", g_d, 0);
      cfg_rd(12'hFB8); check("R6 ue bit20", g_d, 32'h0010_0000);
      cfg_rd(12'h070); check("R6 ds bit19", g_d, 32'h0008_0000);
      send(1, 1, 1, 64'h0000_0000_8002_0608, 1, 4'hF, 32'hCAFE_0000);
      send(1, 0, 0, 64'h8002_0608, 1, 4'hF, 0);
      check("R4 a32 with hi zero", {30'd0, g_st}, 0); check("R6 no write", g_d, 0);
      cfg_wr(12'h014, 32'h0000_0005); cfg_rd(12'h014); check("R3 hi in 64", g_d, 5);
      send(1, 0, 1, 64'h0000_0005_8002_0010, 1, 4'hF, 0);
      check("R5 hit ok", {30'd0, g_st}, 0); check("R5 hit data", g_d, 32'h8002_0004);
      send(1, 0, 1, 64'h0000_0006_8002_0010, 1, 4'hF, 0); check("R5 hi mismatch", {31'd0, g_v}, 0);
      send(1, 0, 0, 64'h8002_0010, 1, 4'hF, 0); check("R5 a32 miss", {31'd0, g_v}, 0);
   endtask

   task automatic t_disable;
      cfg_wr(12'h004, 32'h0);
      send(1, 0, 1, 64'h0000_0005_8002_0010, 1, 4'hF, 0); check("R7 mem off", {31'd0, g_v}, 0);
      cfg_wr(12'h004, 32'h6); cfg_rd(12'h004); check("R7 cmd readback", g_d, 6);
      send(1, 1, 1, 64'h0000_0005_8002_0660, 1, 4'hF, 32'h0200_0000);
      check("R7 ctrl write ok", {31'd0, g_v}, 1);
      send(1, 0, 1, 64'h0000_0005_8002_0010, 1, 4'hF, 0); check("R7 disabled", {31'd0, g_v}, 0);
      cfg_rd(12'h010); check("R7 cfg still works", g_d, 32'h8002_0004);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_fields;
      t_dec32;
      t_be;
      t_overlen;
      t_devcfg;
      t_dec64;
      t_disable;
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule